// File: doc/BRIEF.md
# One-Hot Select Left Shifter

This block shifts a data word toward its most significant end by a binary amount, entirely in combinational logic. The amount is first turned into a set of one-hot select lines. A gated sum-of-products array then forms each result bit by ANDing each select line with the input bit that this shift distance would bring into that position. It ORs those terms together. Positions emptied at the low end receive zeros. Bits pushed past the top are lost and never wrap around.

The word width is a power-of-two parameter. The amount input is log2 of the width in bits, and the decoder produces one select line per bit of the word. The select lines are also driven out on a port, so the one-hot condition can be observed from outside the block. The block holds no state. It suits any datapath that wants a single-level gated-OR shifter rather than a staged multiplexer chain.

Top module: `onehot_lshift`

## Requirements
- R1: For every data word and every amount, `data_out` equals `data_in` shifted left by `amount`, truncated to WIDTH bits.
- R2: Exactly one bit of `select_lines` is 1 for every value of `amount`.
- R3: The set bit of `select_lines` is at index `amount`, so bit k set means a shift of k positions.
- R4: With `amount` equal to 0, `data_out` equals `data_in` bit for bit.
- R5: The `amount` lowest bits of `data_out` are always 0.
- R6: With `amount` equal to WIDTH-1, only the top bit of `data_out` can be nonzero, and it carries bit 0 of `data_in`.
- R7: Bits shifted past the most significant position are discarded. A word with only its top bit set, shifted by any nonzero amount, gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be shifted |
| amount | input | log2(WIDTH) | Binary shift distance |
| data_out | output | WIDTH | Shifted word, zero filled from the bottom |
| select_lines | output | WIDTH | One-hot decoded shift distance, bit k means shift by k |

## Verification
The bench builds the block at its default width of 4, which gives a 2-bit amount and four select lines. At this width the full input space is only 16 words times 4 amounts. The bench therefore sweeps every combination, and every AND term in the array, every decoder output and every zero-fill position gets exercised. Directed cases are then queued on top of the sweep: pass-through at shift 0, the single-bit result at shift 3, and the top-bit word that must vanish.

// File: rtl/shifter_pkg.sv
// Package: shared helpers for the one-hot shifter.
// Assumes: widths passed in are powers of two and at least 2.
package shifter_pkg;

    // Number of bits needed to encode a shift distance below 'width'.
    function automatic int amt_bits(input int width);
        int n;
        n = 0;
        while ((1 << n) < width) begin
            n++;
        end
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/shift_sel_decoder.sv
// Module: binary-to-one-hot decoder for the shift distance.
// Drives select line j high when amt equals j; every other line is low.
// Assumes: OUTS = 2**AMT_W, so every amt value names exactly one line.
module shift_sel_decoder #(
    parameter int OUTS  = 4,
    parameter int AMT_W = 2
) (
    input  logic [AMT_W-1:0] amt,
    output logic [OUTS-1:0]  sel
);

    for (genvar j = 0; j < OUTS; j++) begin : g_line
        // Compare the amount against this line's own index.
        assign sel[j] = (amt == AMT_W'(j));
    end

endmodule

// File: rtl/sop_shift_array.sv
// Module: gated sum-of-products shift network.
// Output bit i ORs (sel[k] AND din[i-k]) over k; terms with i-k < 0 are 0.
// Assumes: sel is one-hot, so at most one term per output bit is live.
module sop_shift_array #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] sel,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] terms [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        for (genvar k = 0; k < WIDTH; k++) begin : g_term
            if (k <= i) begin : g_live
                // AND gate: select line k passes input bit i-k.
                assign terms[i][k] = sel[k] & din[i-k];
            end else begin : g_fill
                // No source bit below index 0: the term is a zero fill.
                assign terms[i][k] = 1'b0;
            end
        end
        // OR gate: collect the gated terms into output bit i.
        assign dout[i] = |terms[i];
    end

endmodule

// File: rtl/onehot_lshift.sv
// Module: left shifter driven by a one-hot decoded shift distance.
// Decodes 'amount' to WIDTH select lines, then feeds a gated AND-OR array.
// Assumes: WIDTH is a power of two, at least 2; purely combinational.
module onehot_lshift #(
    parameter int WIDTH = 4,
    localparam int AMT_W = shifter_pkg::amt_bits(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] data_out,
    output logic [WIDTH-1:0] select_lines
);

    shift_sel_decoder #(
        .OUTS  (WIDTH),
        .AMT_W (AMT_W)
    ) u_dec (
        .amt (amount),
        .sel (select_lines)
    );

    sop_shift_array #(
        .WIDTH (WIDTH)
    ) u_array (
        .din  (data_in),
        .sel  (select_lines),
        .dout (data_out)
    );

endmodule

// File: rtl/onehot_lshift_chk.sv
// Module: assertion checker bound to onehot_lshift.
// Observes the top-level ports only; immediate checks because the block has no clock.
// Assumes: same WIDTH as the bound instance.
module onehot_lshift_chk #(
    parameter int WIDTH = 4,
    localparam int AMT_W = shifter_pkg::amt_bits(WIDTH)
) (
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] amount,
    input logic [WIDTH-1:0] data_out,
    input logic [WIDTH-1:0] select_lines
);

    logic [WIDTH-1:0] low_mask;

    // Mask of the positions that the shift has emptied.
    always_comb low_mask = (WIDTH'(1) << amount) - WIDTH'(1);

    // Port-level relations between amount, select lines and result.
    always_comb begin
        AST_ONE_SELECT: assert ($countones(select_lines) == 1);       // R2
        AST_SELECT_INDEX: assert (select_lines[amount] == 1'b1);      // R3
        AST_LOW_FILL: assert ((data_out & low_mask) == '0);           // R5
        if (amount == '0) begin
            AST_PASS_THROUGH: assert (data_out == data_in);           // R4
        end
        if (amount == AMT_W'(WIDTH-1)) begin
            AST_TOP_ONLY: assert (data_out == {data_in[0], {(WIDTH-1){1'b0}}}); // R6
        end
        if (amount != '0 && data_in == {1'b1, {(WIDTH-1){1'b0}}}) begin
            AST_NO_WRAP: assert (data_out == '0);                     // R7
        end
    end

endmodule

bind onehot_lshift onehot_lshift_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_onehot_lshift.sv
`timescale 1ns/1ps
// Bench: scoreboard for onehot_lshift at WIDTH 4.
// A driver task applies stimulus on the rising edge and queues the expectation;
// a monitor pops and compares on the falling edge.
module test_onehot_lshift;

    localparam int WIDTH = 4;
    localparam int AMT_W = 2;

    typedef struct {
        logic [WIDTH-1:0] exp_data;
        logic [WIDTH-1:0] exp_sel;
        string            tag;
    } item_t;

    logic             clk;
    logic             rst_n;
    logic [WIDTH-1:0] data_in;
    logic [AMT_W-1:0] amount;
    logic [WIDTH-1:0] data_out;
    logic [WIDTH-1:0] select_lines;

    item_t queue_q[$];
    int    n_checks;
    int    n_fail;
    bit    finished;

    onehot_lshift #(.WIDTH(WIDTH)) i_onehot_lshift (
        .data_in      (data_in),
        .amount       (amount),
        .data_out     (data_out),
        .select_lines (select_lines)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Record one comparison.
    task automatic check(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Driver: apply one stimulus and queue its expected result.
    task automatic drive(input logic [WIDTH-1:0] d, input logic [AMT_W-1:0] a,
                         input string tag);
        item_t it;
        @(posedge clk);
        data_in = d;
        amount  = a;
        it.exp_data = WIDTH'(d << a);
        it.exp_sel  = WIDTH'(1) << a;
        it.tag      = tag;
        queue_q.push_back(it);
    endtask

    // Monitor: compare outputs against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            check(it.tag, data_out, it.exp_data);
            check("R3 select index", select_lines, it.exp_sel);
            n_checks++;
            if ($countones(select_lines) != 1) begin
                n_fail++;
                $display("FAIL R2: actual ones %0d expected 1", $countones(select_lines));
            end
        end
    end

    // Stimulus sequence.
    initial begin
        n_checks = 0;
        n_fail   = 0;
        finished = 1'b0;
        rst_n    = 1'b0;
        data_in  = '0;
        amount   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset state data", data_out, 4'b0000);
        check("R3 reset state select", select_lines, 4'b0001);
        rst_n = 1'b1;

        // R1: exhaustive sweep of every word and amount.
        for (int d = 0; d < (1 << WIDTH); d++) begin
            for (int a = 0; a < WIDTH; a++) begin
                drive(WIDTH'(d), AMT_W'(a), "R1 sweep");
            end
        end
        // R4: pass-through at zero shift.
        drive(4'b1011, 2'd0, "R4 pass-through");
        drive(4'b0110, 2'd0, "R4 pass-through");
        // R5: all-ones word exposes the zero fill.
        drive(4'b1111, 2'd1, "R5 fill 1");
        drive(4'b1111, 2'd2, "R5 fill 2");
        // R6: maximum shift leaves only bit 0 at the top.
        drive(4'b0001, 2'd3, "R6 top carries bit0");
        drive(4'b1110, 2'd3, "R6 top only");
        // R7: top bit is lost, never wrapped.
        drive(4'b1000, 2'd1, "R7 no wrap");
        drive(4'b1000, 2'd3, "R7 no wrap");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule